// File: doc/BRIEF.md
# Immediate Codec Command Port

This block gives software a single-shot way to send one 32-bit command word to a codec and collect the codec's 32-bit reply. It does not use the command and response rings. Software loads the command word and then sets the busy bit to launch it. The block holds a request toward the link side until a reply from the addressed codec arrives. Software then polls the status word until the valid bit shows, and reads the response word.

Each command is guarded in two ways. First, the codec address in the top nibble of the command is checked against the number of codecs on the link; a launch to an address outside that range fails at once. Second, a wait timer counts prescaled ticks. If the programmed number of ticks passes with no reply, the command is abandoned, an error bit is raised and the response reads as all ones.

The register file has four words, selected by `reg_addr`:

- 0: the command word.
- 1: the response word.
- 2: the status word.
- 3: the timeout limit, counted in ticks.

Top module: `imm_cmd_port`

## Requirements
- R1: After reset, the status word (reg 2) reads 0, the command and response words read 0, the timeout limit (reg 3) reads 50, and `link_req` is low.
- R2: A write to the command word (reg 2'd0) while busy is clear stores the data. A write to it while busy is set is ignored: the old word reads back and stays on `link_cmd`.
- R3: Writing 1 to status bit 0 (busy) while busy is clear, with a legal address, sets busy on the next clock. From that clock, `link_req` is high, `link_cmd` equals the command word and `link_addr` equals its bits 31:28. Writing bit 0 again while busy has no effect.
- R4: While busy, a `link_rsp_valid` pulse whose `link_rsp_addr` equals command bits 31:28 has three effects at that clock edge: the data goes into the response word, status bit 1 (valid) sets, and busy and `link_req` clear.
- R5: A reply whose address does not match, or one that arrives while busy is clear, changes neither the status word nor the response word.
- R6: Writing 1 to status bit 1 clears valid, and writing 0 there leaves it. A single write of 3'b011 clears valid and launches in the same cycle.
- R7: If no matching reply arrives within limit × TICK_DIV clocks after the launch edge, busy clears, status bit 2 (error) sets, valid stays 0 and the response reads 32'hFFFF_FFFF. Busy still reads 1 one clock before that point. A reply and the timeout on the same edge resolve as a reply.
- R8: A write to reg 3 sets the timeout limit and reads back. The limit is taken at launch, so a later command times out after the new limit × TICK_DIV clocks.
- R9: A launch whose address (bits 31:28) is NUM_CODECS or more (15 by default) does not set busy or raise `link_req`. At the next clock the error bit sets and the response reads all ones.
- R10: Writing 1 to status bit 2 clears the error bit. The error bit is set on the same edge if a failure also occurs then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 response, 2 status, 3 timeout limit |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| link_req | output | 1 | Command outstanding toward the link |
| link_cmd | output | 32 | Command word being sent |
| link_addr | output | 4 | Codec address of the outstanding command |
| link_rsp_valid | input | 1 | Reply strobe from the link |
| link_rsp_addr | input | 4 | Codec address the reply came from |
| link_rsp_data | input | 32 | Reply word |

## Verification
Every result of this block is registered once, so the effect of a register write or a reply pulse is visible on the first clock edge after it. The bench drives each stimulus for one cycle between falling edges and reads back on the next falling edge, which places every read exactly one edge after the cause. The timeout is due limit × TICK_DIV edges after the launch edge. The bench counts that many falling edges minus one, expects busy still set, then moves one more edge and expects the error state. This pins the boundary from both sides, both for the default limit and for a reprogrammed one.

// File: rtl/imm_cmd_pkg.sv
// Shared constants for the immediate command port: register indices,
// status bit positions and the codec address field of a command word.
package imm_cmd_pkg;
    localparam int CMD_W      = 32;
    localparam int CAD_MSB    = 31;
    localparam int CAD_LSB    = 28;
    localparam int CAD_W      = CAD_MSB - CAD_LSB + 1;

    typedef enum logic [1:0] {
        RG_CMD  = 2'd0,
        RG_RESP = 2'd1,
        RG_STAT = 2'd2,
        RG_TMO  = 2'd3
    } reg_sel_e;

    localparam int ST_BUSY  = 0;
    localparam int ST_VALID = 1;
    localparam int ST_ERR   = 2;
endpackage

// File: rtl/imm_addr_check.sv
// Extracts the codec address from a command word and reports whether it
// names a codec that exists. Assumes codecs occupy addresses 0..NUM_CODECS-1.
module imm_addr_check
    import imm_cmd_pkg::*;
#(
    parameter int NUM_CODECS = 15
) (
    input  logic [CMD_W-1:0] cmd,
    output logic [CAD_W-1:0] cad,
    output logic             cad_ok
);
    localparam int LIMIT_W = CAD_W + 1;

    // Field slice and range compare against the codec count.
    always_comb begin
        cad    = cmd[CAD_MSB:CAD_LSB];
        cad_ok = {1'b0, cad} < LIMIT_W'(NUM_CODECS);
    end
endmodule

// File: rtl/imm_tick_gen.sv
// Prescaler for the reply timer: while enabled it emits one tick every
// TICK_DIV clocks, the first tick TICK_DIV clocks after it was restarted.
// Assumes restart and enable are driven from the same clock domain.
module imm_tick_gen #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic en,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    // Tick fires on the last count of each interval.
    assign tick = en && (pre_q == PRE_LAST);

    // Interval counter: cleared on restart or when idle, wraps on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en || tick) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
    end

    // R7: the interval count never passes the divider's last value
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
endmodule

// File: rtl/imm_wait_timer.sv
// Counts prescaled ticks of an outstanding command and flags expiry when the
// count reaches the limit captured at launch (a limit of 0 expires on the
// first tick). Assumes start is a one-cycle pulse before run goes high.
module imm_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] tcnt_q;
    logic [TMO_W-1:0] lim_run_q;
    logic [TMO_W:0]   next_cnt;

    // Expiry when this tick makes the count reach the captured limit.
    always_comb begin
        next_cnt = {1'b0, tcnt_q} + (TMO_W+1)'(1);
        expire   = run && tick && (next_cnt >= {1'b0, lim_run_q});
    end

    // Tick counter and limit capture, both restarted at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            lim_run_q <= '0;
        end else if (start) begin
            tcnt_q    <= '0;
            lim_run_q <= limit;
        end else if (run && tick) begin
            tcnt_q    <= next_cnt[TMO_W-1:0];
        end
    end

    // R7: without a tick the count holds
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(tcnt_q));

    // R8: the captured limit stays fixed while the command runs
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> $stable(lim_run_q));
endmodule

// File: rtl/imm_cmd_port.sv
// Immediate command port: command, response, status and timeout-limit words,
// a link request held while a command is outstanding, a codec address check
// and a prescaled reply timeout. Assumes software polls status; replies carry
// the address of the codec that sent them.
module imm_cmd_port
    import imm_cmd_pkg::*;
#(
    parameter int NUM_CODECS  = 15,
    parameter int TICK_DIV    = 16,
    parameter int TMO_W       = 8,
    parameter int TMO_DEFAULT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             link_req,
    output logic [31:0]      link_cmd,
    output logic [3:0]       link_addr,
    input  logic             link_rsp_valid,
    input  logic [3:0]       link_rsp_addr,
    input  logic [31:0]      link_rsp_data
);
    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] resp_q;
    logic [TMO_W-1:0] lim_q;
    logic             busy_q, valid_q, err_q;

    logic [CAD_W-1:0] cad;
    logic             cad_ok;
    logic             tick, expire;
    logic             cmd_wr, stat_wr, tmo_wr;
    logic             launch_req, launch_ok, launch_bad, rsp_hit, tmo_fire;

    imm_addr_check #(.NUM_CODECS(NUM_CODECS)) u_acheck (
        .cmd    (cmd_q),
        .cad    (cad),
        .cad_ok (cad_ok)
    );

    imm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch_ok),
        .en      (busy_q),
        .tick    (tick)
    );

    imm_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (launch_ok),
        .run    (busy_q),
        .tick   (tick),
        .limit  (lim_q),
        .expire (expire)
    );

    // Decode of register writes, launches, matching replies and expiry.
    always_comb begin
        cmd_wr     = reg_wr && (reg_addr == RG_CMD);
        stat_wr    = reg_wr && (reg_addr == RG_STAT);
        tmo_wr     = reg_wr && (reg_addr == RG_TMO);
        launch_req = stat_wr && reg_wdata[ST_BUSY] && !busy_q;
        launch_ok  = launch_req && cad_ok;
        launch_bad = launch_req && !cad_ok;
        rsp_hit    = busy_q && link_rsp_valid && (link_rsp_addr == cad);
        tmo_fire   = expire && !rsp_hit;
    end

    // Command word: loadable only while no command is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmd_q <= '0;
        else if (cmd_wr && !busy_q) cmd_q <= reg_wdata;
    end

    // Timeout limit word.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_q <= TMO_W'(TMO_DEFAULT);
        else if (tmo_wr) lim_q <= reg_wdata[TMO_W-1:0];
    end

    // Busy: set by a legal launch, cleared by a reply or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   busy_q <= 1'b0;
        else if (rsp_hit || tmo_fire) busy_q <= 1'b0;
        else if (launch_ok)           busy_q <= 1'b1;
    end

    // Valid: set by a reply, write-1-to-clear; a reply wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n)                                valid_q <= 1'b0;
        else if (rsp_hit)                          valid_q <= 1'b1;
        else if (stat_wr && reg_wdata[ST_VALID])   valid_q <= 1'b0;
    end

    // Error: set by expiry or a bad address, write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (tmo_fire || launch_bad)         err_q <= 1'b1;
        else if (stat_wr && reg_wdata[ST_ERR])   err_q <= 1'b0;
    end

    // Response word: reply data, or all ones on any failure.
    always_ff @(posedge clk) begin
        if (!rst_n)                        resp_q <= '0;
        else if (rsp_hit)                  resp_q <= link_rsp_data;
        else if (tmo_fire || launch_bad)   resp_q <= '1;
    end

    // Read mux and link-side outputs.
    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            RG_CMD:  reg_rdata = cmd_q;
            RG_RESP: reg_rdata = resp_q;
            RG_STAT: reg_rdata = {29'd0, err_q, valid_q, busy_q};
            default: reg_rdata = {{(32-TMO_W){1'b0}}, lim_q};
        endcase
        link_req  = busy_q;
        link_cmd  = cmd_q;
        link_addr = cad;
    end

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(cmd_q));

    // R3
    launch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ok |=> (link_req && link_cmd == $past(cmd_q)));

    // R4
    rsp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |=> (!busy_q && valid_q && resp_q == $past(link_rsp_data)));

    // R7
    tmo_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (!busy_q && err_q && resp_q == '1));

    // R9
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_bad |=> (!link_req && err_q && resp_q == '1));
endmodule

// File: tb/imm_cmd_port_test.sv
// Directed bench for imm_cmd_port with default parameters.
module imm_cmd_port_test;
    localparam int DIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_req;
    logic [31:0] link_cmd;
    logic [3:0]  link_addr;
    logic        link_rsp_valid = 1'b0;
    logic [3:0]  link_rsp_addr = '0;
    logic [31:0] link_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    imm_cmd_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_req(link_req),
        .link_cmd(link_cmd), .link_addr(link_addr),
        .link_rsp_valid(link_rsp_valid), .link_rsp_addr(link_rsp_addr),
        .link_rsp_data(link_rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic reply(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        link_rsp_valid = 1'b1; link_rsp_addr = a; link_rsp_data = d;
        @(negedge clk);
        link_rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(2, v); chk("R1 status", v, 32'd0);
        rd_reg(0, v); chk("R1 cmd", v, 32'd0);
        rd_reg(1, v); chk("R1 resp", v, 32'd0);
        rd_reg(3, v); chk("R1 limit", v, 32'd50);
        chk("R1 link_req", {31'd0, link_req}, 32'd0);
    endtask

    task automatic t_reply();
        logic [31:0] v;
        wr_reg(0, 32'h2123_4567);
        rd_reg(0, v); chk("R2 cmd stored", v, 32'h2123_4567);
        wr_reg(2, 32'h1);
        rd_reg(2, v); chk("R3 busy set", v, 32'h1);
        chk("R3 link_req", {31'd0, link_req}, 32'd1);
        chk("R3 link_cmd", link_cmd, 32'h2123_4567);
        chk("R3 link_addr", {28'd0, link_addr}, 32'd2);
        wr_reg(0, 32'hDEAD_BEEF);
        rd_reg(0, v); chk("R2 write ignored while busy", v, 32'h2123_4567);
        chk("R2 link_cmd held", link_cmd, 32'h2123_4567);
        wr_reg(2, 32'h1);
        rd_reg(2, v); chk("R3 relaunch no effect", v, 32'h1);
        reply(4'd5, 32'h1111_1111);
        rd_reg(2, v); chk("R5 wrong address ignored", v, 32'h1);
        rd_reg(1, v); chk("R5 resp untouched", v, 32'd0);
        reply(4'd2, 32'hCAFE_0001);
        rd_reg(2, v); chk("R4 valid set busy clear", v, 32'h2);
        rd_reg(1, v); chk("R4 resp captured", v, 32'hCAFE_0001);
        chk("R4 link_req dropped", {31'd0, link_req}, 32'd0);
        reply(4'd2, 32'h5555_5555);
        rd_reg(1, v); chk("R5 idle reply ignored", v, 32'hCAFE_0001);
        rd_reg(2, v); chk("R5 idle status", v, 32'h2);
    endtask

    task automatic t_clear_valid();
        logic [31:0] v;
        wr_reg(2, 32'h0);
        rd_reg(2, v); chk("R6 write 0 keeps valid", v, 32'h2);
        wr_reg(2, 32'h2);
        rd_reg(2, v); chk("R6 write 1 clears valid", v, 32'h0);
        wr_reg(0, 32'h3000_00AA);
        wr_reg(2, 32'h1);
        reply(4'd3, 32'h0000_0BBB);
        rd_reg(2, v); chk("R6 second reply valid", v, 32'h2);
        wr_reg(2, 32'h3);
        rd_reg(2, v); chk("R6 clear valid and launch", v, 32'h1);
        reply(4'd3, 32'h0000_0CCC);
        rd_reg(1, v); chk("R4 second capture", v, 32'h0000_0CCC);
        wr_reg(2, 32'h2);
    endtask

    task automatic t_timeout(input int lim, input string tag);
        logic [31:0] v;
        wr_reg(0, 32'h1000_0042);
        wr_reg(2, 32'h1);
        repeat (lim * DIV - 1) @(negedge clk);
        rd_reg(2, v); chk({tag, " busy before limit"}, v, 32'h1);
        @(negedge clk);
        rd_reg(2, v); chk({tag, " error at limit"}, v, 32'h4);
        rd_reg(1, v); chk({tag, " resp all ones"}, v, 32'hFFFF_FFFF);
        chk({tag, " link_req low"}, {31'd0, link_req}, 32'd0);
        wr_reg(2, 32'h4);
        rd_reg(2, v); chk("R10 error cleared", v, 32'h0);
    endtask

    task automatic t_prog_limit();
        logic [31:0] v;
        wr_reg(3, 32'd2);
        rd_reg(3, v); chk("R8 limit readback", v, 32'd2);
        t_timeout(2, "R8");
    endtask

    task automatic t_bad_addr();
        logic [31:0] v;
        wr_reg(0, 32'hF000_0001);
        wr_reg(2, 32'h1);
        rd_reg(2, v); chk("R9 error no busy", v, 32'h4);
        chk("R9 no link_req", {31'd0, link_req}, 32'd0);
        rd_reg(1, v); chk("R9 resp all ones", v, 32'hFFFF_FFFF);
        wr_reg(2, 32'h0);
        rd_reg(2, v); chk("R10 write 0 keeps error", v, 32'h4);
        wr_reg(2, 32'h4);
        rd_reg(2, v); chk("R10 error cleared", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reply();
        t_clear_valid();
        t_timeout(50, "R7");
        t_prog_limit();
        t_bad_addr();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule